// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

This block turns characters into asynchronous serial frames on a single output line. A character enters through a one-entry holding stage with a valid/ready handshake. The shift engine takes it from there as soon as it is free, and sends it at the rate set by an oversampling tick from an external rate generator. The line settings are plain control inputs and are captured when the shift engine takes each character: data width of 5 to 8 bits, parity on or off with four parity rules, and one, one-and-a-half or two stop bits. A break input forces the line low.

Back-pressure works as follows. `in_ready` is high exactly when the holding stage is empty. A character is taken on a rising clock edge where `in_valid` and `in_ready` are both high. A producer that sees `in_ready` low must keep `in_valid` and `in_data` steady until it is taken. When a character is waiting as the current frame's last stop tick arrives, the next start bit follows with no idle gap. Two status outputs report whether a character is waiting and whether the whole transmitter is idle.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset, and whenever the transmitter is idle with break off, `txd` is 1. Out of reset `hold_empty`, `tx_empty` and `in_ready` are all 1.
- R2: A frame is one 0 start bit, then the data bits least significant first, then the optional parity bit, then the stop bits at 1. `wlen_code` 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. Unused upper data bits are not sent.
- R3: With `par_en` at 1, one parity bit follows the data. It is computed over the data bits actually sent. `par_mode` 0 gives odd parity, 1 gives even parity, 2 gives a constant 1 and 3 gives a constant 0. With `par_en` at 0, no parity bit is sent.
- R4: `stop_sel` 0 gives a stop time of OVS ticks. `stop_sel` 1 gives 2*OVS ticks, or 1.5*OVS ticks when `wlen_code` is 0.
- R5: While `brk_en` is 1, `txd` is 0. The frame sequence keeps running underneath, so a character sent during break is still consumed and the transmitter returns to idle on time.
- R6: `in_ready` equals the emptiness of the holding stage. A character is accepted on an edge with `in_valid` and `in_ready` both high, and is never lost or duplicated. A character waiting when the current frame ends starts immediately, with no idle gap.
- R7: `hold_empty` goes to 0 in the cycle after a character is accepted. It returns to 1 in the cycle after the shift engine takes that character.
- R8: `tx_empty` is 1 only when both the holding stage and the shift engine are idle. It never reads 1 while `hold_empty` is 0.
- R9: Each start, data and parity bit lasts OVS ticks. `txd` does not change during cycles without a tick while a frame is in progress and nothing is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Holding stage can accept a character |
| tick | input | 1 | Oversampling tick, one clock wide |
| wlen_code | input | 2 | Data width code (5 + code bits) |
| stop_sel | input | 1 | Stop length select |
| par_en | input | 1 | Parity bit enable |
| par_mode | input | 2 | Parity rule: odd, even, forced 1, forced 0 |
| brk_en | input | 1 | Force the line low |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | No character waiting in the holding stage |
| tx_empty | output | 1 | Holding stage and shift engine both idle |

## Verification
The status outputs respond one cycle after their cause. `hold_empty` and `in_ready` change in the cycle after acceptance. `hold_empty` returns one cycle later, when the shift engine takes the character, and the bench samples each of these on the falling edge just after the edge concerned. Line timing depends on the tick phase at the moment of loading, so bit boundaries can move by one clock. The scoreboard monitor therefore detects each start bit and then samples at bit centres, half a bit after each boundary. Stop length is measured as the spacing between the start bits of back-to-back frames, and this spacing is compared with 2*ticks clocks within one clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Parity rule codes
  localparam logic [1:0] PAR_ODD  = 2'd0;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ONE  = 2'd2;
  localparam logic [1:0] PAR_ZERO = 2'd3;

  // Narrowest data width (code 0)
  localparam int unsigned MIN_BITS = 5;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop2;
    logic       par_en;
    logic [1:0] par_mode;
  } line_cfg_t;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_BITS = 2'd1,
    SH_STOP = 2'd2
  } sh_state_e;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic push;

  assign in_ready = !full;
  assign push     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (push) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              src_full,
  input  logic [DATA_W-1:0] src_data,
  input  line_cfg_t         cfg,
  output logic              take,
  output logic              busy,
  output logic              line
);

  localparam int unsigned FRM_W = DATA_W + 2;            // start + data + parity
  localparam int unsigned LW    = $clog2(FRM_W + 1);
  localparam int unsigned TW    = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned SW    = $clog2(2 * OVS + 1);

  sh_state_e        state;
  logic [FRM_W-1:0] sreg;
  logic [LW-1:0]    left;
  logic [TW-1:0]    tcnt;
  logic [SW-1:0]    scnt;
  logic [SW-1:0]    slen;

  logic [FRM_W-1:0] frame_nxt;
  logic [LW-1:0]    left_nxt;
  logic [SW-1:0]    slen_nxt;
  logic             pbit;
  logic             bit_end;
  logic             stop_end;

  // Frame image built from the waiting character and current settings
  always_comb begin
    int unsigned nb;
    logic        x;
    nb        = MIN_BITS + int'(cfg.wlen);
    x         = 1'b0;
    frame_nxt = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nb) begin
        frame_nxt[i+1] = src_data[i];
        x              = x ^ src_data[i];
      end
    end
    case (cfg.par_mode)
      PAR_ODD:  pbit = ~x;
      PAR_EVEN: pbit = x;
      PAR_ONE:  pbit = 1'b1;
      default:  pbit = 1'b0;
    endcase
    for (int i = 0; i < FRM_W; i++) begin
      if (cfg.par_en && (i == nb + 1)) frame_nxt[i] = pbit;
    end
    left_nxt = LW'(1 + nb + int'(cfg.par_en));
    if (!cfg.stop2)          slen_nxt = SW'(OVS);
    else if (cfg.wlen == '0) slen_nxt = SW'(OVS + OVS / 2);
    else                     slen_nxt = SW'(2 * OVS);
  end

  assign bit_end  = tick && (tcnt == TW'(OVS - 1));
  assign stop_end = tick && (scnt == slen - SW'(1));
  assign take     = src_full && ((state == SH_IDLE) || (state == SH_STOP && stop_end));
  assign busy     = (state != SH_IDLE);
  assign line     = (state == SH_BITS) ? sreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      sreg  <= '1;
      left  <= '0;
      tcnt  <= '0;
      scnt  <= '0;
      slen  <= SW'(OVS);
    end else if (take) begin
      state <= SH_BITS;
      sreg  <= frame_nxt;
      left  <= left_nxt;
      slen  <= slen_nxt;
      tcnt  <= '0;
      scnt  <= '0;
    end else begin
      case (state)
        SH_BITS: begin
          if (bit_end) begin
            tcnt <= '0;
            sreg <= {1'b1, sreg[FRM_W-1:1]};
            left <= left - LW'(1);
            if (left == LW'(1)) begin
              state <= SH_STOP;
              scnt  <= '0;
            end
          end else if (tick) begin
            tcnt <= tcnt + TW'(1);
          end
        end
        SH_STOP: begin
          if (stop_end)  state <= SH_IDLE;
          else if (tick) scnt  <= scnt + SW'(1);
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              tick,
  input  logic [1:0]        wlen_code,
  input  logic              stop_sel,
  input  logic              par_en,
  input  logic [1:0]        par_mode,
  input  logic              brk_en,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty
);

  line_cfg_t         cfg;
  logic              take;
  logic              full;
  logic [DATA_W-1:0] hdata;
  logic              busy;
  logic              line;

  assign cfg = '{wlen: wlen_code, stop2: stop_sel, par_en: par_en, par_mode: par_mode};

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .take     (take),
    .full     (full),
    .data     (hdata)
  );

  uart_tx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .src_full (full),
    .src_data (hdata),
    .cfg      (cfg),
    .take     (take),
    .busy     (busy),
    .line     (line)
  );

  // Break only overrides the level; the engine keeps running
  assign txd        = brk_en ? 1'b0 : line;
  assign hold_empty = !full;
  assign tx_empty   = !full && !busy;

endmodule

// File: rtl/uart_tx_serializer_chk.sv
module uart_tx_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic tick,
  input logic brk_en,
  input logic txd,
  input logic hold_empty,
  input logic tx_empty
);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk_en) |-> txd);

  // R5
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_en |-> !txd);

  // R8
  temt_needs_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);

  // R6
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!hold_empty && !in_ready));

  // R7
  drain_to_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> !tx_empty);

  // R9
  no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && hold_empty && !tx_empty && !brk_en) |=> (brk_en || $stable(txd)));

endmodule

bind uart_tx_serializer uart_tx_serializer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .tick       (tick),
  .brk_en     (brk_en),
  .txd        (txd),
  .hold_empty (hold_empty),
  .tx_empty   (tx_empty)
);

// File: tb/uart_tx_serializer_tb.sv
module uart_tx_serializer_tb;

  localparam int OVS  = 16;
  localparam int BITC = 2 * OVS;   // tick every other clock
  localparam int HALF = OVS;

  typedef struct {
    logic [9:0] bits;
    int         n;
    int         npar;
    int         frame_cyc;
    bit         chain;
  } exp_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] in_data = '0;
  logic       in_valid = 0;
  logic       in_ready;
  logic       tick;
  logic       tick_en = 1;
  logic [1:0] wlen_code = 2'd3;
  logic       stop_sel = 0;
  logic       par_en = 0;
  logic [1:0] par_mode = 0;
  logic       brk_en = 0;
  logic       txd, hold_empty, tx_empty;

  int  n_chk = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  mon_en = 1;
  bit  done = 0;
  exp_t q[$];

  uart_tx_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tick(tick), .wlen_code(wlen_code), .stop_sel(stop_sel),
    .par_en(par_en), .par_mode(par_mode), .brk_en(brk_en), .txd(txd),
    .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) tick <= 1'b0;
    else        tick <= tick_en ? ~tick : 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Driver: build the expected frame and offer the character
  task automatic send(input logic [7:0] d, input bit chain, input bit expect_it);
    exp_t e;
    int   nb;
    logic x;
    nb = 5 + int'(wlen_code);
    x  = 1'b0;
    e.bits = '0;
    for (int i = 0; i < nb; i++) begin
      e.bits[i] = d[i];
      x = x ^ d[i];
    end
    e.npar = par_en ? 1 : 0;
    if (par_en) begin
      case (par_mode)
        2'd0: e.bits[nb] = ~x;
        2'd1: e.bits[nb] = x;
        2'd2: e.bits[nb] = 1'b1;
        default: e.bits[nb] = 1'b0;
      endcase
    end
    e.n = nb + e.npar;
    if (!stop_sel)              e.frame_cyc = 2 * ((1 + e.n) * OVS + OVS);
    else if (wlen_code == 2'd0) e.frame_cyc = 2 * ((1 + e.n) * OVS + OVS + OVS / 2);
    else                        e.frame_cyc = 2 * ((1 + e.n) * OVS + 2 * OVS);
    e.chain = chain;
    if (expect_it) q.push_back(e);
    @(negedge clk);
    in_valid = 1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_idle();
    while (!tx_empty) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  // Monitor: detect start bits, sample bit centres, compare with queue
  initial begin
    int last_start;
    int last_cyc;
    exp_t it;
    last_start = 0;
    last_cyc   = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (mon_en && !txd) begin
        if (q.size() == 0) begin
          chk(0, "R2 unexpected start bit", 0, 1);
        end else begin
          it = q.pop_front();
          if (it.chain) begin
            int gap;
            gap = cyc - last_start;
            // R4 stop length and R6 no idle gap, seen as start-to-start spacing
            chk((gap >= last_cyc - 1) && (gap <= last_cyc + 1), "R4/R6 frame spacing", gap, last_cyc);
          end
          last_start = cyc;
          last_cyc   = it.frame_cyc;
          repeat (HALF) @(negedge clk);
          chk(txd == 1'b0, "R2 start bit", int'(txd), 0);
          for (int j = 0; j < it.n; j++) begin
            repeat (BITC) @(negedge clk);
            if (j >= it.n - it.npar) chk(txd == it.bits[j], "R3 parity bit", int'(txd), int'(it.bits[j]));
            else                     chk(txd == it.bits[j], "R2 data bit", int'(txd), int'(it.bits[j]));
          end
          repeat (BITC) @(negedge clk);
          chk(txd == 1'b1, "R4 stop bit level", int'(txd), 1);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual %0d expected %0d", cyc, 200000);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(hold_empty == 1'b1, "R1 hold_empty after reset", int'(hold_empty), 1);
    chk(tx_empty == 1'b1, "R1 tx_empty after reset", int'(tx_empty), 1);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R6 R7 R8 status timing with manual drive
    begin
      exp_t e;
      e.bits = 10'h03C; e.n = 8; e.npar = 0; e.chain = 0;
      e.frame_cyc = 2 * (10 * OVS);
      q.push_back(e);
    end
    in_valid = 1; in_data = 8'h3C;
    @(negedge clk);
    in_valid = 0;
    chk(in_ready == 1'b0, "R6 in_ready after accept", int'(in_ready), 0);
    chk(hold_empty == 1'b0, "R7 hold_empty after accept", int'(hold_empty), 0);
    chk(tx_empty == 1'b0, "R8 tx_empty with char waiting", int'(tx_empty), 0);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R7 hold_empty after take", int'(hold_empty), 1);
    chk(tx_empty == 1'b0, "R8 tx_empty while shifting", int'(tx_empty), 0);
    chk(in_ready == 1'b1, "R6 in_ready after take", int'(in_ready), 1);
    wait_idle();
    chk(tx_empty == 1'b1, "R8 tx_empty after frame", int'(tx_empty), 1);

    // R2 word lengths
    for (int w = 0; w < 4; w++) begin
      wlen_code = 2'(w);
      send(8'hA6 ^ 8'(w * 37), 0, 1);
      wait_idle();
    end

    // R3 parity rules
    wlen_code = 2'd3;
    par_en = 1;
    for (int m = 0; m < 4; m++) begin
      par_mode = 2'(m);
      send(8'h5B, 0, 1);
      wait_idle();
      send(8'h13, 0, 1);
      wait_idle();
    end
    wlen_code = 2'd1;
    par_mode = 2'd0;
    send(8'hE9, 0, 1);
    wait_idle();
    par_en = 0;

    // R4 stop lengths, R6 back-to-back
    wlen_code = 2'd3; stop_sel = 0;
    send(8'h81, 0, 1); send(8'h7E, 1, 1); send(8'h00, 1, 1);
    wait_idle();
    stop_sel = 1;
    send(8'hC3, 0, 1); send(8'h3C, 1, 1);
    wait_idle();
    wlen_code = 2'd0;
    send(8'h15, 0, 1); send(8'h0A, 1, 1);
    wait_idle();
    stop_sel = 0;
    send(8'h1F, 0, 1); send(8'h11, 1, 1);
    wait_idle();

    // R5 break
    mon_en = 0;
    wlen_code = 2'd3;
    brk_en = 1;
    send(8'hFF, 0, 0);
    repeat (50) @(negedge clk);
    chk(txd == 1'b0, "R5 txd during break", int'(txd), 0);
    chk(tx_empty == 1'b0, "R5 frame running under break", int'(tx_empty), 0);
    begin
      int waited;
      waited = 0;
      while (!tx_empty && waited < 2000) begin
        @(negedge clk);
        waited++;
      end
      chk(waited < 400, "R5 frame finished under break", waited, 400);
    end
    chk(hold_empty == 1'b1, "R5 character consumed", int'(hold_empty), 1);
    chk(txd == 1'b0, "R5 idle line still forced low", int'(txd), 0);
    brk_en = 0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 idle high after break", int'(txd), 1);

    // R9 no ticks, no movement
    send(8'h55, 0, 0);
    repeat (100) @(negedge clk);
    tick_en = 0;
    repeat (2) @(negedge clk);
    begin
      logic v;
      bit   stable;
      v = txd;
      stable = 1;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (txd !== v) stable = 0;
      end
      chk(stable, "R9 line frozen without ticks", int'(stable), 1);
    end
    chk(tx_empty == 1'b0, "R9 frame held without ticks", int'(tx_empty), 0);
    tick_en = 1;
    wait_idle();
    mon_en = 1;

    chk(q.size() == 0, "R6 all characters sent", q.size(), 0);
    finish_run();
  end

endmodule